// File: doc/BRIEF.md
# Cascaded Decimal Digit Counter

This block counts clock edges in decimal across a chain of BCD digit stages (three by default: units, tens, hundreds), all on one clock. A single enable input selects the edges that count. Each stage is a mod-10 counter with a registered wrap flag. The flag rises on the edge where the stage rolls over from 9 to 0. It clears on the next edge that has the enable high.

A stage above the units advances only on an edge where the enable is high and the stage below it has its wrap flag set. The inter-stage carry is therefore always gated by the global enable. A flag that stays set through a pause cannot advance a higher digit while counting is stopped, and it cannot advance it more than once after counting resumes. Because the carry passes through a register per stage, stage k lags the units by k enabled edges. The digit outputs therefore form a skewed count, which is fully defined by R4. A terminal carry output reports the wrap flag of the top stage while the enable is high.

Top module: `bcd_count_chain`

## Requirements
- R1: When rst_ni is low, all digits, all wrap flags and carry_o become zero at once, without waiting for a clock edge.
- R2: The units digit increments by one on each rising edge with en_i high, goes from 9 to 0, and never holds a code above 9.
- R3: On a rising edge with en_i low, no digit changes, and carry_o is 0 for as long as en_i is low.
- R4: After n enabled edges since reset, digit k (units k=0) equals floor((n-k)/10^k) mod 10 when n >= k, and 0 otherwise.
- R5: A stage's wrap flag is set by the enabled edge that takes the stage from 9 to 0. It is cleared by the next edge with en_i high, however many cycles with en_i low lie between the two.
- R6: Stage k>0 changes only on an edge where en_i is high and the wrap flag of stage k-1 is set. A flag held over a pause advances the higher digit exactly once, on the first enabled edge after the pause.
- R7: carry_o is high exactly when en_i is high and the top stage's wrap flag is set, that is when n >= 3 and (n-2) mod 1000 = 0 for three digits.
- R8: digits_o carries digit k in bits [4k+3:4k], with units in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global count enable |
| digits_o | output | 4*NUM_DIGITS | Packed BCD digits, units in the low nibble |
| carry_o | output | 1 | Top-stage wrap flag gated by en_i |

## Verification
Two things can land on the same cycle: a pause in counting, and a wrap flag that is still set. The bench provokes this by dropping en_i for several cycles right after a units rollover, a tens rollover and a hundreds rollover. It also inserts short periodic pauses during a sweep of more than two full cycles of the counter. Every cycle is judged at the ports against an integer tick count and the skewed-digit formula. The checks confirm that no higher digit moves during a pause, that each one moves exactly once after the pause, and that carry_o stays low during the pause and comes back high when counting resumes.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned DEF_RADIX  = 10;
  localparam int unsigned DEF_DIGITS = 3;
  localparam int unsigned DEF_W      = $clog2(DEF_RADIX);
endpackage

// File: rtl/bcd_stage.sv
module bcd_stage #(
  parameter int unsigned RADIX = bcd_pkg::DEF_RADIX,
  parameter int unsigned W     = $clog2(RADIX)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         inc_i,
  output logic [W-1:0] digit_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = W'(RADIX - 1);

  logic [W-1:0] digit_q;
  logic         wrap_q;
  logic         at_top;

  assign at_top = (digit_q == TOP);

  // wrap flag lives for exactly one enabled tick, digit only moves on inc
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      digit_q <= '0;
      wrap_q  <= 1'b0;
    end else if (tick_i) begin
      wrap_q <= inc_i && at_top;
      if (inc_i) digit_q <= at_top ? '0 : digit_q + W'(1);
    end
  end

  assign digit_o = digit_q;
  assign wrap_o  = wrap_q;

  // R2
  digit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    digit_q <= TOP);

  // R3
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(digit_q) && $stable(wrap_q)));

  // R5
  wrap_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_q) |-> (digit_q == '0 && $past(inc_i)));

  // R5
  wrap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_q && tick_i) |=> !wrap_q);
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
  parameter int unsigned N = bcd_pkg::DEF_DIGITS
) (
  input  logic         en_i,
  input  logic [N-1:0] wrap_i,
  output logic [N-1:0] inc_o,
  output logic         carry_o
);
  // every carry is qualified by the global enable, never by a raw flag
  assign inc_o[0] = en_i;
  for (genvar k = 1; k < N; k++) begin : g_link
    assign inc_o[k] = en_i && wrap_i[k-1];
  end
  assign carry_o = en_i && wrap_i[N-1];
endmodule

// File: rtl/bcd_count_chain.sv
module bcd_count_chain #(
  parameter int unsigned NUM_DIGITS = bcd_pkg::DEF_DIGITS,
  parameter int unsigned RADIX      = bcd_pkg::DEF_RADIX,
  parameter int unsigned W          = $clog2(RADIX)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  output logic [NUM_DIGITS*W-1:0] digits_o,
  output logic                  carry_o
);
  logic [NUM_DIGITS-1:0] wrap_w;
  logic [NUM_DIGITS-1:0] inc_w;
  logic [W-1:0]          digit_w [NUM_DIGITS];

  bcd_chain #(.N(NUM_DIGITS)) u_chain (
    .en_i   (en_i),
    .wrap_i (wrap_w),
    .inc_o  (inc_w),
    .carry_o(carry_o)
  );

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
    bcd_stage #(.RADIX(RADIX), .W(W)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (en_i),
      .inc_i  (inc_w[k]),
      .digit_o(digit_w[k]),
      .wrap_o (wrap_w[k])
    );
    // R8
    assign digits_o[k*W +: W] = digit_w[k];
  end

  for (genvar k = 1; k < NUM_DIGITS; k++) begin : g_chk
    // R6
    gated_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (digit_w[k] != $past(digit_w[k])) |-> $past(en_i && wrap_w[k-1]));
  end

  // R7
  carry_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !carry_o);
endmodule

// File: tb/sim_bcd_count_chain.sv
module sim_bcd_count_chain;
  localparam int ND = 3;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            en_i = 1'b0;
  logic [ND*4-1:0] digits_o;
  logic            carry_o;

  int checks = 0;
  int errors = 0;
  int n = 0;
  bit last_paused = 1'b0;

  bcd_count_chain u0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .digits_o(digits_o),
    .carry_o (carry_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic int pow10(input int k);
    int p = 1;
    for (int i = 0; i < k; i++) p = p * 10;
    return p;
  endfunction

  function automatic int exp_digit(input int cnt, input int k);
    if (cnt < k) return 0;
    return ((cnt - k) / pow10(k)) % 10;
  endfunction

  function automatic bit exp_wrap(input int cnt, input int k);
    return (cnt >= k + 1) && (((cnt - k) % pow10(k + 1)) == 0);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (n=%0d)", tag, got, exp, n);
    end
  endtask

  task automatic check_all(input bit e);
    for (int k = 0; k < ND; k++) begin
      string tag;
      if (k == 0) tag = e ? "R2 R8 units" : "R3 units";
      else if (!e) tag = $sformatf("R3 R6 digit%0d", k);
      else if (last_paused) tag = $sformatf("R5 R6 digit%0d", k);
      else tag = $sformatf("R4 R8 digit%0d", k);
      chk(tag, int'(digits_o[k*4 +: 4]), exp_digit(n, k));
    end
    chk("R7 carry", int'(carry_o), int'(e && exp_wrap(n, ND - 1)));
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input bit e);
    en_i = e;
    @(posedge clk_i);
    if (e) n++;
    @(negedge clk_i);
    check_all(e);
    last_paused = !e;
  endtask

  task automatic pause(input int cycles);
    for (int i = 0; i < cycles; i++) step(1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en_i = 1'b1;
    #12;
    // R1 reset state with enable high
    chk("R1 digits", int'(digits_o), 0);
    chk("R1 carry", int'(carry_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;

    // sweep past two full rollovers with pauses over live wrap flags
    for (int i = 0; i < 2100; i++) begin
      step(1'b1);
      if (n == 10 || n == 101 || n == 102 || n == 1002 || n == 2002) pause(5);
      else if (i % 37 == 20) pause(2);
    end

    // R1 asynchronous reset mid-count
    @(negedge clk_i);
    en_i = 1'b1;
    #2;
    rst_ni = 1'b0;
    #1;
    chk("R1 async digits", int'(digits_o), 0);
    chk("R1 async carry", int'(carry_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n = 0;
    last_paused = 1'b0;
    for (int i = 0; i < 25; i++) step(1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule